// File: doc/BRIEF.md
# DMA Channel Address Pointer Unit with Peripheral Resynchronisation

This block produces the source and destination addresses for one DMA channel. Each pointer has two pairs of registers. Software writes a shadow pair, made of a base shadow and a pointer shadow. Hardware owns an active pair, made of an active base and an active pointer. On a start strobe, each active register takes its own shadow. The active pointer moves by a signed per-word step on every advance strobe. A burst counter counts burst-end strobes. When it runs out, both pointers wrap: the active base moves by a signed wrap step and the active pointer jumps to the new base.

A peripheral sends a sync pulse, which should coincide with a wrap or with a start. A pulse at any other moment is a sync error. The block then resynchronises: the burst counter reloads, the selected pointer returns to its active base, and a sticky error flag is set. A control bit selects whether resynchronisation acts on the source or on the destination pointer. Halt conditions freeze the pointer activity at a strobe boundary.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `src_addr` and `dst_addr` are 0, and `sync_err` and `halted` are 0.
- R2: On `start`, each active base takes its own base shadow and each active pointer takes its own pointer shadow. Shadows change only by register writes, so a later `start` reloads the same values.
- R3: On `adv` with no start, wrap or resync, each active pointer adds its sign-extended 16-bit per-word step, modulo 2^22.
- R4: Each `burst_end` decrements the burst counter. A `burst_end` that finds the counter at 1 or 0 causes a wrap on both pointers: base += sign-extended wrap step, pointer = new base. The counter then reloads from the wrap size. A wrap overrides `adv` in the same cycle. `start` loads the counter from the wrap size.
- R5: A `sync_pulse` in the same cycle as `start` or a wrap causes no error and no extra action.
- R6: With sync enabled, a `sync_pulse` at any other time is a sync error. The selected active pointer reloads from its active base, which stays unchanged. The counter reloads from the wrap size and `sync_err` goes to 1. The other pointer still obeys `adv` in that cycle.
- R7: Control bit 0 selects the pointer that resync acts on: 0 selects source, 1 selects destination.
- R8: `sync_err` is sticky. A control write with bit 4 = 1 clears it. A new sync error in the same cycle wins over the clear.
- R9: `halted` = control bit 3 (halt command) OR `preempt` OR (`dbg_halt` AND NOT control bit 2, free-run). While `halted` is 1, `start`, `adv`, `burst_end` and `sync_pulse` are ignored.
- R10: With control bit 1 (sync enable) = 0, `sync_pulse` has no effect.
- R11: Write map for `wr_sel`:
  - 0: source base shadow, bits 21:0.
  - 1: source pointer shadow, bits 21:0.
  - 2: destination base shadow, bits 21:0.
  - 3: destination pointer shadow, bits 21:0.
  - 4: source per-word step in bits 15:0 and source wrap step in bits 31:16.
  - 5: destination per-word step in bits 15:0 and destination wrap step in bits 31:16.
  - 6: wrap size in bits 15:0.
  - 7: control, with bit 0 sync target, bit 1 sync enable, bit 2 free-run, bit 3 halt command, and bit 4 clear sync error (write-1, not stored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Transfer start strobe |
| adv | input | 1 | Per-word advance strobe |
| burst_end | input | 1 | End-of-burst strobe |
| sync_pulse | input | 1 | Peripheral sync pulse |
| preempt | input | 1 | Higher-priority channel takes the bus |
| dbg_halt | input | 1 | Debug halt request |
| src_addr | output | 22 | Active source pointer |
| dst_addr | output | 22 | Active destination pointer |
| sync_err | output | 1 | Sticky sync error flag |
| halted | output | 1 | Channel paused |

## Verification
A resync and a word advance can fall in the same cycle. The resynced pointer must land on its base, while the other pointer must still take its step. Directed cycles drive `sync_pulse` with `adv` away from any wrap, once with each sync target, and compare both addresses with a bench model. Random phases raise all strobes at once with small wrap sizes, so a sync also lands on wraps, on plain advances and on clear writes. The model judges each of these cycles.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
    typedef enum logic [2:0] {
        SEL_SRC_BEG  = 3'd0,
        SEL_SRC_PTR  = 3'd1,
        SEL_DST_BEG  = 3'd2,
        SEL_DST_PTR  = 3'd3,
        SEL_SRC_STEP = 3'd4,
        SEL_DST_STEP = 3'd5,
        SEL_WRAP     = 3'd6,
        SEL_CTRL     = 3'd7
    } reg_sel_e;

    // packed: last field is bit 0
    typedef struct packed {
        logic clr_err;
        logic halt_cmd;
        logic free_run;
        logic sync_en;
        logic sync_dst;
    } ctrl_t;

    localparam int NUM_PTR = 2;
endpackage

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
    parameter int AW = 22,
    parameter int SW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_beg,
    input  logic          wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [SW-1:0] step,
    input  logic [SW-1:0] wrap_step,
    input  logic          do_start,
    input  logic          do_wrap,
    input  logic          do_resync,
    input  logic          do_adv,
    output logic [AW-1:0] addr_o
);
    localparam int EXT = AW - SW;

    typedef struct packed {
        logic [AW-1:0] sh_beg;
        logic [AW-1:0] sh_ptr;
        logic [AW-1:0] act_beg;
        logic [AW-1:0] act_ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [AW-1:0] step_x, wstep_x, new_beg;

    always_comb begin
        step_x  = {{EXT{step[SW-1]}}, step};
        wstep_x = {{EXT{wrap_step[SW-1]}}, wrap_step};
        new_beg = st_q.act_beg + wstep_x;
        st_d    = st_q;
        if (wr_beg) st_d.sh_beg = wr_data[AW-1:0];
        if (wr_ptr) st_d.sh_ptr = wr_data[AW-1:0];
        if (do_start) begin
            st_d.act_beg = st_q.sh_beg;
            st_d.act_ptr = st_q.sh_ptr;
        end else if (do_wrap) begin
            st_d.act_beg = new_beg;
            st_d.act_ptr = new_beg;
        end else if (do_resync) begin
            st_d.act_ptr = st_q.act_beg;
        end else if (do_adv) begin
            st_d.act_ptr = st_q.act_ptr + step_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.act_ptr;

    assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        do_start |=> (st_q.act_ptr == $past(st_q.sh_ptr)) && (st_q.act_beg == $past(st_q.sh_beg)))
        else $error("start load mismatch");

    assert_shadow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_beg && !wr_ptr |=> $stable(st_q.sh_beg) && $stable(st_q.sh_ptr))
        else $error("shadow changed without write");

    assert_wrap_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_wrap && !do_start |=> st_q.act_ptr == st_q.act_beg)
        else $error("wrap pointer not at base");

    assert_resync_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_resync && !do_start && !do_wrap |=> (st_q.act_ptr == $past(st_q.act_beg)) && $stable(st_q.act_beg))
        else $error("resync pointer mismatch");
endmodule

// File: rtl/dma_wrap_ctl.sv
module dma_wrap_ctl #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          start,
    input  logic          burst_end,
    input  logic          sync_pulse,
    input  logic          sync_en,
    input  logic          clr_err,
    input  logic [CW-1:0] wrap_size,
    output logic          do_wrap,
    output logic          do_resync,
    output logic          sync_err
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
    } wrap_state_t;

    wrap_state_t ws_d, ws_q;
    logic go;

    always_comb begin
        go        = run && !start;
        do_wrap   = go && burst_end && (ws_q.cnt <= CW'(1));
        do_resync = go && sync_pulse && sync_en && !do_wrap;
        ws_d      = ws_q;
        if ((run && start) || do_wrap || do_resync) ws_d.cnt = wrap_size;
        else if (go && burst_end)                    ws_d.cnt = ws_q.cnt - CW'(1);
        ws_d.err = (ws_q.err && !clr_err) || do_resync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_q <= '0;
        else        ws_q <= ws_d;
    end

    assign sync_err = ws_q.err;

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err && !clr_err |=> sync_err)
        else $error("sync error flag dropped");

    assert_err_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_resync |=> sync_err)
        else $error("sync error not raised");

    assert_cnt_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        do_wrap || do_resync |=> ws_q.cnt == $past(wrap_size))
        else $error("counter not reloaded");

    assert_aligned_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wrap || (run && start)) && !sync_err && !clr_err |=> !sync_err)
        else $error("aligned sync flagged");
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_addr_pkg::*;
#(
    parameter int AW = 22,
    parameter int SW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          start,
    input  logic          adv,
    input  logic          burst_end,
    input  logic          sync_pulse,
    input  logic          preempt,
    input  logic          dbg_halt,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          sync_err,
    output logic          halted
);
    typedef struct packed {
        logic [NUM_PTR-1:0][SW-1:0] step;
        logic [NUM_PTR-1:0][SW-1:0] wstep;
        logic [CW-1:0]              wrap_size;
        ctrl_t                      ctrl;
    } cfg_t;

    cfg_t  cfg_d, cfg_q;
    ctrl_t wr_ctrl;
    logic  clr_err, run, do_wrap, do_resync;
    logic [NUM_PTR-1:0][AW-1:0] addr;

    always_comb begin
        wr_ctrl = ctrl_t'(wr_data[4:0]);
        cfg_d   = cfg_q;
        clr_err = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_SRC_STEP: begin
                    cfg_d.step[0]  = wr_data[SW-1:0];
                    cfg_d.wstep[0] = wr_data[2*SW-1:SW];
                end
                SEL_DST_STEP: begin
                    cfg_d.step[1]  = wr_data[SW-1:0];
                    cfg_d.wstep[1] = wr_data[2*SW-1:SW];
                end
                SEL_WRAP: cfg_d.wrap_size = wr_data[CW-1:0];
                SEL_CTRL: begin
                    cfg_d.ctrl         = wr_ctrl;
                    cfg_d.ctrl.clr_err = 1'b0;
                    clr_err            = wr_ctrl.clr_err;
                end
                default: ;
            endcase
        end
        halted = cfg_q.ctrl.halt_cmd || preempt || (dbg_halt && !cfg_q.ctrl.free_run);
        run    = !halted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    dma_wrap_ctl #(.CW(CW)) u_wrap (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start),
        .burst_end(burst_end), .sync_pulse(sync_pulse),
        .sync_en(cfg_q.ctrl.sync_en), .clr_err(clr_err),
        .wrap_size(cfg_q.wrap_size), .do_wrap(do_wrap),
        .do_resync(do_resync), .sync_err(sync_err)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        logic sel_me;
        assign sel_me = (cfg_q.ctrl.sync_dst == (g == 1));
        dma_ptr_unit #(.AW(AW), .SW(SW), .DW(DW)) u_ptr (
            .clk(clk), .rst_n(rst_n),
            .wr_beg(wr_en && (wr_sel == 3'(2*g))),
            .wr_ptr(wr_en && (wr_sel == 3'(2*g+1))),
            .wr_data(wr_data),
            .step(cfg_q.step[g]), .wrap_step(cfg_q.wstep[g]),
            .do_start(run && start), .do_wrap(do_wrap),
            .do_resync(do_resync && sel_me),
            .do_adv(run && adv),
            .addr_o(addr[g])
        );
    end

    assign src_addr = addr[0];
    assign dst_addr = addr[1];

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(src_addr) && $stable(dst_addr))
        else $error("pointer moved while halted");

    assert_sync_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.ctrl.sync_en && !sync_err |=> !sync_err)
        else $error("error with sync disabled");
endmodule

// File: tb/dma_addr_gen_bench.sv
module dma_addr_gen_bench;
    logic        clk = 0, rst_n = 0;
    logic        wr_en = 0, start = 0, adv = 0, burst_end = 0, sync_pulse = 0, preempt = 0, dbg_halt = 0;
    logic [2:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [21:0] src_addr, dst_addr;
    logic        sync_err, halted;

    int vec = 0, bad = 0;
    bit done = 0;
    string tag = "R1";

    // model state
    logic [21:0] m_sb[2], m_sp[2], m_ab[2], m_ap[2];
    logic [15:0] m_st[2], m_ws[2], m_wsize, m_cnt;
    logic [3:0]  m_ctrl;
    logic        m_err;

    always #10 clk = ~clk;

    dma_addr_gen u_dma_addr_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .start(start), .adv(adv), .burst_end(burst_end), .sync_pulse(sync_pulse),
        .preempt(preempt), .dbg_halt(dbg_halt), .src_addr(src_addr), .dst_addr(dst_addr),
        .sync_err(sync_err), .halted(halted)
    );

    function automatic logic m_halt(input logic pre, input logic dbg);
        return m_ctrl[3] || pre || (dbg && !m_ctrl[2]);
    endfunction

    function automatic logic [21:0] sx(input logic [15:0] v);
        return {{6{v[15]}}, v};
    endfunction

    task automatic model(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                         input logic st, input logic ad, input logic be, input logic sy,
                         input logic pre, input logic dbg);
        logic h, wrp, serr, clr;
        h    = m_halt(pre, dbg);
        clr  = we && sel == 3'd7 && wd[4];
        wrp  = !h && !st && be && (m_cnt <= 16'd1);
        serr = !h && !st && sy && m_ctrl[1] && !wrp;
        if (!h && st) begin
            for (int p = 0; p < 2; p++) begin m_ab[p] = m_sb[p]; m_ap[p] = m_sp[p]; end
            m_cnt = m_wsize;
        end else if (!h) begin
            for (int p = 0; p < 2; p++) begin
                if (wrp) begin m_ab[p] = m_ab[p] + sx(m_ws[p]); m_ap[p] = m_ab[p]; end
                else if (serr && (m_ctrl[0] == (p == 1))) m_ap[p] = m_ab[p];
                else if (ad) m_ap[p] = m_ap[p] + sx(m_st[p]);
            end
            if (wrp || serr) m_cnt = m_wsize;
            else if (be) m_cnt = m_cnt - 16'd1;
        end
        m_err = (m_err && !clr) || serr;
        if (we) begin
            case (sel)
                3'd0: m_sb[0] = wd[21:0];
                3'd1: m_sp[0] = wd[21:0];
                3'd2: m_sb[1] = wd[21:0];
                3'd3: m_sp[1] = wd[21:0];
                3'd4: begin m_st[0] = wd[15:0]; m_ws[0] = wd[31:16]; end
                3'd5: begin m_st[1] = wd[15:0]; m_ws[1] = wd[31:16]; end
                3'd6: m_wsize = wd[15:0];
                default: m_ctrl = wd[3:0];
            endcase
        end
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        chk("src_addr", 32'(src_addr), 32'(m_ap[0]));
        chk("dst_addr", 32'(dst_addr), 32'(m_ap[1]));
        chk("sync_err", 32'(sync_err), 32'(m_err));
        chk("halted",   32'(halted),   32'(m_halt(preempt, dbg_halt)));
    endtask

    task automatic cyc(input logic we, input logic [2:0] sel, input logic [31:0] wd,
                       input logic st, input logic ad, input logic be, input logic sy,
                       input logic pre, input logic dbg);
        wr_en = we; wr_sel = sel; wr_data = wd; start = st; adv = ad;
        burst_end = be; sync_pulse = sy; preempt = pre; dbg_halt = dbg;
        @(posedge clk);
        model(we, sel, wd, st, ad, be, sy, pre, dbg);
        @(negedge clk);
        wr_en = 0; start = 0; adv = 0; burst_end = 0; sync_pulse = 0;
        check_all();
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] wd);
        cyc(1, sel, wd, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; vec++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int p = 0; p < 2; p++) begin
            m_sb[p] = 0; m_sp[p] = 0; m_ab[p] = 0; m_ap[p] = 0; m_st[p] = 0; m_ws[p] = 0;
        end
        m_wsize = 0; m_cnt = 0; m_ctrl = 0; m_err = 0;
        repeat (3) @(negedge clk);
        tag = "R1"; check_all();
        rst_n = 1;
        @(negedge clk);

        tag = "R11";
        wr(3'd0, 32'h0000_1000); wr(3'd1, 32'h0000_1010);
        wr(3'd2, 32'h0002_0000); wr(3'd3, 32'h0002_0004);
        wr(3'd4, 32'h0100_0004); wr(3'd5, 32'hFFC0_FFFE);
        wr(3'd6, 32'd2);         wr(3'd7, 32'h0000_0002);

        tag = "R5";  cyc(0, 0, 0, 1, 0, 0, 1, 0, 0);   // start + sync: no error
        tag = "R2";  chk("src after start", 32'(src_addr), 32'h1010);
        tag = "R3";  repeat (3) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("dst after 3 advances", 32'(dst_addr), 32'h1FFFE);
        tag = "R4";  cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 1, 1, 0, 0);                 // wrap + adv + sync
        chk("src at wrapped base", 32'(src_addr), 32'h1100);
        tag = "R5";  chk("no error at wrap", 32'(sync_err), 0);
        tag = "R6";  cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0);                 // early sync + adv
        chk("src back to base", 32'(src_addr), 32'h1100);
        chk("dst still stepped", 32'(dst_addr), 32'h1FFBC);
        cyc(0, 0, 0, 0, 0, 1, 0, 0, 0);                 // counter reloaded: no wrap
        chk("no wrap after resync", 32'(src_addr), 32'h1100);
        tag = "R8";  idle();
        chk("err sticky", 32'(sync_err), 1);
        wr(3'd7, 32'h12);
        chk("err cleared", 32'(sync_err), 0);
        cyc(1, 3'd7, 32'h12, 0, 0, 0, 1, 0, 0);         // set beats clear
        chk("set wins clear", 32'(sync_err), 1);
        tag = "R7";  wr(3'd7, 32'h13);
        cyc(0, 0, 0, 0, 1, 0, 1, 0, 0);
        chk("src stepped", 32'(src_addr), 32'h1104);
        chk("dst at base", 32'(dst_addr), 32'h1FFC0);
        tag = "R10"; wr(3'd7, 32'h10);
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0);
        chk("sync ignored", 32'(sync_err), 0);
        tag = "R9";  wr(3'd7, 32'h0A);
        cyc(0, 0, 0, 1, 1, 1, 1, 0, 0);
        chk("halt cmd", 32'(halted), 1);
        chk("frozen src", 32'(src_addr), 32'h1104);
        wr(3'd7, 32'h02);
        cyc(0, 0, 0, 0, 1, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1);
        wr(3'd7, 32'h06);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 1);                 // free-run: advances
        chk("free-run runs", 32'(halted), 0);
        tag = "R2";  wr(3'd7, 32'h02);
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("restart src", 32'(src_addr), 32'h1010);
        chk("restart dst", 32'(dst_addr), 32'h20004);

        tag = "RND";
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [2:0]  sel;
            logic [31:0] wd;
            we  = ($urandom_range(0, 19) == 0);
            sel = 3'($urandom_range(0, 7));
            wd  = $urandom();
            if (sel == 3'd6) wd = 32'($urandom_range(0, 4));
            if (sel == 3'd7) wd = wd & (($urandom_range(0, 4) == 0) ? 32'h1F : 32'h17);
            cyc(we, sel, wd, $urandom_range(0, 29) == 0, 1'($urandom()), $urandom_range(0, 2) == 0,
                $urandom_range(0, 5) == 0, $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule